// File: doc/BRIEF.md
# Multiplexed Address Memory Interface

This block puts a 16-bit memory address onto an 8-bit address port in two successive bytes and produces the read and write controls for one memory access. A request carries the address, a direction bit and, for writes, one data byte. Once the block accepts a request, it drives the upper address byte first and raises a one-cycle strobe. An external register uses that strobe to capture the upper address bits it needs. The block then drives the lower byte from its own register and holds it until the next request, so no outside storage is needed for that byte.

Every access runs through the same four one-clock phases: upper byte, lower byte, access, and finish. During the access phase the block raises a read level or a write pulse. The write pulse comes only after the lower byte has been stable for one full clock. A clock-enable input freezes the sequencer with every output held, which lets the surrounding system pause the interface. The project also includes a model of the external upper-bit register for a 4096-byte memory. That model joins 4 captured bits with the 8 lower bits to form a 12-bit physical address.

Top module: `mux_addr_mem_if`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous clear), all state returns to idle: `busy`, `hi_strobe`, `rd_level`, `wr_pulse` and `data_oe` are 0, and `mem_addr`, `data_out` and `phys_addr` are 0.
- R2: A request is accepted at an enabled edge when `req_valid` is 1 and the block is idle. In the first cycle after acceptance, `mem_addr` equals address bits 15:8 and `hi_strobe` is 1. `hi_strobe` is 1 in no other cycle.
- R3: From the second cycle after acceptance onward, `mem_addr` equals address bits 7:0. It stays at that value through the end of the access and while idle, until the next request is accepted.
- R4: `phys_addr` is {the 4 bits captured from `mem_addr[3:0]` while `hi_strobe` was 1, `mem_addr`}. From the second cycle after acceptance onward it equals address bits 11:0.
- R5: For a write (`req_write`=1), `wr_pulse` is 1 only in the third cycle after acceptance, and the lower byte has then already been on `mem_addr` for one cycle. `data_oe` is 1 in cycles two to four, and `data_out` then equals the write byte. `rd_level` stays 0.
- R6: For a read (`req_write`=0), `rd_level` is 1 only in the third cycle after acceptance. `wr_pulse` and `data_oe` stay 0, and `data_out` stays 0.
- R7: `busy` is 1 in cycles one to four after acceptance and 0 otherwise. A new request can be accepted at the first enabled edge where `busy` is 0.
- R8: A request presented while `busy` is 1 is ignored. The running access keeps its address, direction, data and timing.
- R9: While `clk_en` is 0, the edge changes nothing. Every output keeps its value, and a pending request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous clear, active low |
| clk_en | input | 1 | Clock enable; 0 freezes the block |
| req_valid | input | 1 | Request an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| mem_addr | output | 8 | Multiplexed address byte |
| hi_strobe | output | 1 | Upper address byte is on `mem_addr` |
| rd_level | output | 1 | Read enable level |
| wr_pulse | output | 1 | Write pulse |
| data_out | output | 8 | Byte for the data bus |
| data_oe | output | 1 | Data bus drive enable |
| busy | output | 1 | Access in progress |
| phys_addr | output | 12 | Physical address from the external register model |

## Verification
A wrong phase register shows up at the ports within one cycle. The strobe, the byte on `mem_addr`, or the read or write control appears in the wrong cycle, and `busy` ends too early or too late. A corrupted captured address or write byte appears on `mem_addr`, `phys_addr` or `data_out` in the first cycle that uses it. A failed freeze appears as an output that changes during a cycle with `clk_en` low. The bench also sends ignored requests in the middle of accesses, so a capture register that is wrongly enabled changes the lower byte within two cycles.

// File: rtl/mai_pkg.sv
// Shared types for the multiplexed address memory interface.
// Assumes: one access in flight at a time.
package mai_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ADDR_HI = 3'd1,
        PH_ADDR_LO = 3'd2,
        PH_ACCESS  = 3'd3,
        PH_DONE    = 3'd4
    } mai_phase_e;
endpackage

// File: rtl/mai_seq.sv
// Phase sequencer: accepts a request while idle, captures it, and steps
// through the fixed phases one clock each. Assumes clk_en gates every update.
module mai_seq
    import mai_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output mai_phase_e        phase,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q
);
    // Phase advance and request capture, frozen while clk_en is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (clk_en) begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase   <= PH_ADDR_HI;
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                    end
                end
                PH_ADDR_HI: phase <= PH_ADDR_LO;
                PH_ADDR_LO: phase <= PH_ACCESS;
                PH_ACCESS:  phase <= PH_DONE;
                default:    phase <= PH_IDLE;
            endcase
        end
    end

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(phase) && $stable(addr_q)); // R9
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(addr_q) && $stable(write_q) && $stable(wdata_q)); // R8
    AST_ONE_CLOCK_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && phase == PH_ADDR_HI) |=> phase == PH_ADDR_LO); // R7
endmodule

// File: rtl/mai_drive.sv
// Output decode: selects the address byte by phase and raises the strobe,
// read level, write pulse and data enable. Assumes ADDR_W = 2*BUS_W.
module mai_drive
    import mai_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 8,
    parameter int DATA_W = 8
) (
    input  mai_phase_e        phase,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              write_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [BUS_W-1:0]  mem_addr,
    output logic              hi_strobe,
    output logic              rd_level,
    output logic              wr_pulse,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              busy
);
    localparam int HI_LSB = ADDR_W - BUS_W;

    logic in_data_window;

    // Address byte mux: upper byte only during the strobe phase.
    always_comb begin
        if (phase == PH_ADDR_HI) mem_addr = addr_q[ADDR_W-1:HI_LSB];
        else                     mem_addr = addr_q[BUS_W-1:0];
    end

    // Control decode for strobe, access levels and bus drive.
    always_comb begin
        hi_strobe      = (phase == PH_ADDR_HI);
        busy           = (phase != PH_IDLE);
        rd_level       = (phase == PH_ACCESS) && !write_q;
        wr_pulse       = (phase == PH_ACCESS) && write_q;
        in_data_window = (phase == PH_ADDR_LO) || (phase == PH_ACCESS) || (phase == PH_DONE);
        data_oe        = in_data_window && write_q;
        data_out       = data_oe ? wdata_q : '0;
    end
endmodule

// File: rtl/mai_hi_latch.sv
// Model of the external upper-address register: captures the low HI_BITS
// of the address port while the strobe is high and joins them with the port.
module mai_hi_latch #(
    parameter int BUS_W   = 8,
    parameter int HI_BITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic                     strobe,
    input  logic [BUS_W-1:0]         bus_in,
    output logic [HI_BITS+BUS_W-1:0] phys_addr
);
    logic [HI_BITS-1:0] hi_bits_q;

    // Capture the needed upper bits during the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hi_bits_q <= '0;
        else if (clk_en && strobe)  hi_bits_q <= bus_in[HI_BITS-1:0];
    end

    assign phys_addr = {hi_bits_q, bus_in};

    AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && strobe) |=> phys_addr[HI_BITS+BUS_W-1:BUS_W] == $past(bus_in[HI_BITS-1:0])); // R4
endmodule

// File: rtl/mux_addr_mem_if.sv
// Top: multiplexed address memory interface with the external upper-address
// register model. Assumes one access at a time and a synchronous active-low clear.
module mux_addr_mem_if
    import mai_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BUS_W   = 8,
    parameter int DATA_W  = 8,
    parameter int HI_BITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic [BUS_W-1:0]         mem_addr,
    output logic                     hi_strobe,
    output logic                     rd_level,
    output logic                     wr_pulse,
    output logic [DATA_W-1:0]        data_out,
    output logic                     data_oe,
    output logic                     busy,
    output logic [HI_BITS+BUS_W-1:0] phys_addr
);
    mai_phase_e        phase;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;

    mai_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .phase(phase), .addr_q(addr_q), .write_q(write_q), .wdata_q(wdata_q)
    );

    mai_drive #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W)) u_drive (
        .phase(phase), .addr_q(addr_q), .write_q(write_q), .wdata_q(wdata_q),
        .mem_addr(mem_addr), .hi_strobe(hi_strobe), .rd_level(rd_level),
        .wr_pulse(wr_pulse), .data_out(data_out), .data_oe(data_oe), .busy(busy)
    );

    mai_hi_latch #(.BUS_W(BUS_W), .HI_BITS(HI_BITS)) u_hi_latch (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .strobe(hi_strobe), .bus_in(mem_addr), .phys_addr(phys_addr)
    );

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && hi_strobe) |=> !hi_strobe && busy); // R2
    AST_LO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && busy && !hi_strobe) |=> $stable(mem_addr)); // R3
    AST_WR_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_pulse) |-> $stable(mem_addr) && !$past(hi_strobe) && $past(busy)); // R5
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_level && (wr_pulse || data_oe))); // R6
    AST_CTRL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_level || wr_pulse || hi_strobe || data_oe) |-> busy); // R7
endmodule

// File: tb/mux_addr_mem_if_tb.sv
// Bench: directed corner cases plus seeded random accesses, with random
// stalls and ignored requests during busy; expectations from bench functions.
module mux_addr_mem_if_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  mem_addr;
    logic        hi_strobe, rd_level, wr_pulse, data_oe, busy;
    logic [7:0]  data_out;
    logic [11:0] phys_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    mux_addr_mem_if u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_addr(mem_addr), .hi_strobe(hi_strobe), .rd_level(rd_level),
        .wr_pulse(wr_pulse), .data_out(data_out), .data_oe(data_oe),
        .busy(busy), .phys_addr(phys_addr)
    );

    always #10 clk = ~clk;

    // Expected packed outputs {busy,hi,rd,wr,oe,mem_addr,data_out} for cycle k after acceptance (5 = idle after)
    function automatic logic [20:0] exp_out(int k, logic [15:0] a, logic w, logic [7:0] d);
        logic [7:0] ma = (k == 1) ? a[15:8] : a[7:0];
        logic oe = w && (k >= 2) && (k <= 4);
        return {(k >= 1 && k <= 4), (k == 1), (!w && k == 3), (w && k == 3), oe, ma, oe ? d : 8'h00};
    endfunction

    function automatic logic [20:0] act_out();
        return {busy, hi_strobe, rd_level, wr_pulse, data_oe, mem_addr, data_out};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_phase(int k, logic [15:0] a, logic w, logic [7:0] d);
        string tag = (k == 1) ? "R2" : (k == 3) ? (w ? "R5" : "R6") : (k == 5) ? "R7" : "R3";
        check(tag, act_out(), exp_out(k, a, w, d));
        if (k >= 2) check("R4", phys_addr, a[11:0]);
    endtask

    // One access with optional random stalls and ignored busy requests.
    task automatic run_op(logic [15:0] a, logic w, logic [7:0] d, bit noise);
        logic [20:0] held;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; clk_en = 1'b1;
        step();
        for (int k = 1; k <= 5; k++) begin
            if (k == 5) req_valid = 1'b0;
            check_phase(k, a, w, d);
            if (k == 5) break;
            if (noise) begin
                req_valid = $urandom_range(0, 1);
                req_write = $urandom_range(0, 1);
                req_addr  = $urandom;
                req_wdata = $urandom;
            end else begin
                req_valid = 1'b0;
            end
            if (noise && $urandom_range(0, 2) == 0) begin
                held = act_out();
                clk_en = 1'b0;
                step();
                check("R9", act_out(), held);
                clk_en = 1'b1;
            end
            step();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) step();
        check("R1", {act_out(), phys_addr}, 33'h0);
        rst_n = 1'b1;
        step();
        check("R1", {act_out(), phys_addr}, 33'h0);
        // Directed: write, read, extreme addresses
        run_op(16'hA5C3, 1'b1, 8'h3C, 1'b0);
        run_op(16'h1F2E, 1'b0, 8'hFF, 1'b0);
        run_op(16'hFFFF, 1'b1, 8'h00, 1'b0);
        run_op(16'h0000, 1'b0, 8'h55, 1'b0);
        // Stall while idle with a request pending: not accepted (R9)
        clk_en = 1'b0; req_valid = 1'b1; req_addr = 16'h1234; req_write = 1'b1;
        step(); step();
        check("R9", {busy, mem_addr}, {1'b0, 8'h00});
        req_valid = 1'b0;
        // Ignored busy request, directed (R8)
        run_op(16'h9ABC, 1'b1, 8'h77, 1'b1);
        // Random mix
        for (int i = 0; i < 60; i++)
            run_op(16'($urandom), 1'($urandom_range(0, 1)), 8'($urandom), 1'b1);
        // Back-to-back acceptance right after busy drops (R7)
        run_op(16'h4321, 1'b0, 8'h00, 1'b0);
        run_op(16'h8765, 1'b1, 8'hE1, 1'b0);
        // Clear in the middle of an access (R1)
        req_valid = 1'b1; req_addr = 16'hBEEF; req_write = 1'b1; req_wdata = 8'h11;
        step(); req_valid = 1'b0; step();
        rst_n = 1'b0; step();
        check("R1", {act_out(), phys_addr}, 33'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule